// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral that sits on a plain synchronous register bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. The block has one output level, one output enable and one sampled input for each pin. The pin count equals the register width, which may be 8, 16, 32 or 64 bits.

Software sees up to four windows of equal size: a data window, a set window, a clear window and a direction window. Three write schemes are chosen at elaboration:
- **Data-only.** A write to the data window loads the whole output latch.
- **Set-only.** The set window is the output latch, and the data window only reports the pins.
- **Set plus clear.** The set and clear windows give atomic per-bit updates.

The direction window is either absent, so the pins always drive, or present with one of two polarities. In one polarity a 1 enables the output. In the other a 1 selects input.

Two further elaboration options change how pins map onto bus bits. Bit reversal maps pin n to bit (width-1-n). Byte swapping reverses the byte order of every bus word. Byte swapping at 64 bits is rejected at elaboration, as is any width outside 8, 16, 32 and 64. Pin inputs cross a two-flop synchronizer before software can see them.

Top module: `gpio_mmio`

## Requirements
- R1: After a synchronous active-high reset the output latch and the direction register are all zeros and `rdata` is zero. `pin_oe` is therefore all zeros with output-high polarity and all ones with input-high polarity or with no direction register.
- R2: A read of the data window (byte offset 0) returns `pin_in` through two flops. After `pin_in` changes, reads whose strobe covers the first or second following rising edge return the old level, and the third returns the new one.
- R3: In data-only mode a write to the data window loads the entire output latch onto `pin_out`. Writes to the set and clear offsets have no effect, and the set and clear offsets read as zero.
- R4: In set-plus-clear mode each 1 bit written to the set window drives that pin high, and each 1 bit written to the clear window drives it low. Bits written as 0 leave the latch unchanged. The set window reads back the latch and the clear window reads zero.
- R5: In set-only mode a write to the set window loads the whole latch, and a read of it returns the latch. In both set modes, writes to the data window have no effect on `pin_out`.
- R6: With output-high direction polarity, `pin_oe` equals the direction register, so a 1 bit enables the output. The direction window reads back the written value.
- R7: With input-high direction polarity, `pin_oe` is the complement of the direction register, so a 1 bit makes the pin an input.
- R8: With no direction register, `pin_oe` stays all ones. Writes to the direction offset are ignored, and the direction offset reads zero.
- R9: With bit reversal enabled, pin n appears at bus bit (width-1-n) in every window, for both writes and reads.
- R10: With byte swapping enabled, bus byte k carries register byte (width/8-1-k) in every window, for both writes and reads.
- R11: The windows lie at byte offsets 0, B, 2B and 3B for data, set, clear and direction, where B is the register width divided by 8. A read of any other offset, or of a window the build lacks, returns zero. A write to such an offset changes nothing.
- R12: `rdata` is loaded at the rising edge where `rd_en` is high, and it holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | REG_W | Write data in bus order |
| rdata | output | REG_W | Registered read data in bus order |
| pin_in | input | REG_W | Asynchronous pin input levels |
| pin_out | output | REG_W | Output latch driving the pins |
| pin_oe | output | REG_W | Per-pin output enable |

## Verification
Three builds are exercised side by side:
- A 16-bit set-plus-clear build with output-high direction, which tells the set and clear paths apart through overlapping masks, all-zero masks that must change nothing, and whole-word masks.
- A 32-bit set-only build with both bit reversal and byte swapping, which uses single-bit and asymmetric words such as 0x00000001 and 0x12345678. These separate a correct reversal-plus-swap mapping from either transform alone and from no mapping at all.
- An 8-bit data-only build without direction, which uses a pin level different from the latched value so that data reads prove they report the pins rather than the latch.

A pin change followed by three back-to-back reads checks the synchronizer depth. A write that comes without a read checks that read data holds.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    // Output write scheme selected at elaboration
    typedef enum logic [1:0] {
        WR_DATA_ONLY = 2'd0,
        WR_SET_ONLY  = 2'd1,
        WR_SET_CLEAR = 2'd2
    } wr_mode_e;

    // Direction register presence and polarity
    typedef enum logic [1:0] {
        DIR_NONE    = 2'd0,
        DIR_OE_HIGH = 2'd1,
        DIR_IN_HIGH = 2'd2
    } dir_mode_e;

    // Decoded read target
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DATA = 3'd1,
        SEL_SET  = 3'd2,
        SEL_CLR  = 3'd3,
        SEL_DIR  = 3'd4
    } reg_sel_e;

    // Per-window write strobes
    typedef struct packed {
        logic data;
        logic set;
        logic clr;
        logic dir;
    } wr_stb_t;

    // Window index; byte offset = index * register bytes
    localparam int WIN_DATA = 0;
    localparam int WIN_SET  = 1;
    localparam int WIN_CLR  = 2;
    localparam int WIN_DIR  = 3;
    localparam int WIN_COUNT = 4;

    function automatic bit width_legal(int w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

    function automatic bit config_legal(int w, bit swap);
        return width_legal(w) && !(swap && (w == 64));
    endfunction

endpackage

// File: rtl/gpio_mmio_order_map.sv
// Bit-reversal and byte-swap transform between pin order and bus order.
// Both transforms are involutions and commute, so one block serves both directions.
module gpio_mmio_order_map #(
    parameter int unsigned REG_W     = 32,
    parameter bit          BIT_REV   = 1'b0,
    parameter bit          BYTE_SWAP = 1'b0
) (
    input  logic [REG_W-1:0] din,
    output logic [REG_W-1:0] dout
);
    localparam int unsigned NBYTES = REG_W / 8;

    logic [REG_W-1:0] rev;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (BIT_REV) begin : g_rev
            assign rev[i] = din[REG_W-1-i];
        end else begin : g_keep
            assign rev[i] = din[i];
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        if (BYTE_SWAP) begin : g_swap
            assign dout[8*b +: 8] = rev[8*(NBYTES-1-b) +: 8];
        end else begin : g_straight
            assign dout[8*b +: 8] = rev[8*b +: 8];
        end
    end
endmodule

// File: rtl/gpio_mmio_decode.sv
// Address decode: window selection for reads and per-window write strobes.
module gpio_mmio_decode
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned REG_W    = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter wr_mode_e    WR_MODE  = WR_SET_CLEAR,
    parameter dir_mode_e   DIR_MODE = DIR_OE_HIGH
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output wr_stb_t           stb,
    output reg_sel_e          rsel
);
    localparam int unsigned BYTES   = REG_W / 8;
    localparam bit          HAS_SET = (WR_MODE != WR_DATA_ONLY);
    localparam bit          HAS_CLR = (WR_MODE == WR_SET_CLEAR);
    localparam bit          HAS_DIR = (DIR_MODE != DIR_NONE);

    localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(WIN_DATA * BYTES);
    localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(WIN_SET  * BYTES);
    localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(WIN_CLR  * BYTES);
    localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(WIN_DIR  * BYTES);

    always_comb begin
        rsel = SEL_NONE;
        if (addr == OFF_DATA) begin
            rsel = SEL_DATA;
        end else if (HAS_SET && (addr == OFF_SET)) begin
            rsel = SEL_SET;
        end else if (HAS_CLR && (addr == OFF_CLR)) begin
            rsel = SEL_CLR;
        end else if (HAS_DIR && (addr == OFF_DIR)) begin
            rsel = SEL_DIR;
        end
    end

    // The data window is writable only when it is also the output latch
    always_comb begin
        stb.data = wr_en && (rsel == SEL_DATA) && !HAS_SET;
        stb.set  = wr_en && (rsel == SEL_SET);
        stb.clr  = wr_en && (rsel == SEL_CLR);
        stb.dir  = wr_en && (rsel == SEL_DIR);
    end
endmodule

// File: rtl/gpio_mmio_in_sync.sv
// Two-flop input synchronizer.
module gpio_mmio_in_sync #(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] pin_in,
    output logic [REG_W-1:0] sync_q
);
    logic [REG_W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    // Cycles since reset, saturating; gates the two-cycle lookback
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    p_sync_depth_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (sync_q == $past(pin_in, 2)));
endmodule

// File: rtl/gpio_mmio_out_latch.sv
// Output latch with data, set-only or set/clear update schemes.
module gpio_mmio_out_latch
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned REG_W   = 32,
    parameter wr_mode_e    WR_MODE = WR_SET_CLEAR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_data,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [REG_W-1:0] wpin,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] nxt;
    logic [REG_W-1:0] set_bits;
    logic [REG_W-1:0] clr_bits;

    always_comb begin
        set_bits = wr_set ? wpin : '0;
        clr_bits = wr_clr ? wpin : '0;
        nxt      = q;
        if (WR_MODE == WR_DATA_ONLY) begin
            if (wr_data) nxt = wpin;
        end else if (WR_MODE == WR_SET_ONLY) begin
            if (wr_set) nxt = wpin;
        end else begin
            // clear applied last so it wins on any shared bit
            nxt = (q | set_bits) & ~clr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    if (WR_MODE == WR_SET_CLEAR) begin : g_chk_setclr
        p_set_high_r4: assert property (@(posedge clk) disable iff (rst)
            wr_set |=> ((q & $past(wpin)) == $past(wpin)));
        p_clr_low_r4: assert property (@(posedge clk) disable iff (rst)
            wr_clr |=> ((q & $past(wpin)) == '0));
        p_zero_keep_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_set || wr_clr) |=> ((q & ~$past(wpin)) == ($past(q) & ~$past(wpin))));
    end else if (WR_MODE == WR_SET_ONLY) begin : g_chk_set
        p_set_load_r5: assert property (@(posedge clk) disable iff (rst)
            wr_set |=> (q == $past(wpin)));
        p_no_data_wr_r5: assert property (@(posedge clk) disable iff (rst)
            !wr_data);
    end else begin : g_chk_data
        p_data_load_r3: assert property (@(posedge clk) disable iff (rst)
            wr_data |=> (q == $past(wpin)));
        p_no_set_wr_r3: assert property (@(posedge clk) disable iff (rst)
            !(wr_set || wr_clr));
    end
endmodule

// File: rtl/gpio_mmio_dir_ctrl.sv
// Direction register and output-enable polarity.
module gpio_mmio_dir_ctrl
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned REG_W    = 32,
    parameter dir_mode_e   DIR_MODE = DIR_OE_HIGH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_dir,
    input  logic [REG_W-1:0] wpin,
    output logic [REG_W-1:0] dir_q,
    output logic [REG_W-1:0] pin_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
        end else if ((DIR_MODE != DIR_NONE) && wr_dir) begin
            dir_q <= wpin;
        end
    end

    always_comb begin
        case (DIR_MODE)
            DIR_OE_HIGH: pin_oe = dir_q;
            DIR_IN_HIGH: pin_oe = ~dir_q;
            default:     pin_oe = '1;
        endcase
    end

    if (DIR_MODE == DIR_OE_HIGH) begin : g_chk_oe
        p_oe_follows_r6: assert property (@(posedge clk) disable iff (rst)
            wr_dir |=> (pin_oe == $past(wpin)));
    end else if (DIR_MODE == DIR_IN_HIGH) begin : g_chk_in
        p_oe_inverted_r7: assert property (@(posedge clk) disable iff (rst)
            wr_dir |=> (pin_oe == ~$past(wpin)));
    end else begin : g_chk_none
        p_no_dir_wr_r8: assert property (@(posedge clk) disable iff (rst)
            !wr_dir);
    end
endmodule

// File: rtl/gpio_mmio.sv
// Memory-mapped GPIO controller top.
module gpio_mmio
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned REG_W     = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter wr_mode_e    WR_MODE   = WR_SET_CLEAR,
    parameter dir_mode_e   DIR_MODE  = DIR_OE_HIGH,
    parameter bit          BIT_REV   = 1'b0,
    parameter bit          BYTE_SWAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  pin_in,
    output logic [REG_W-1:0]  pin_out,
    output logic [REG_W-1:0]  pin_oe
);
    localparam int unsigned BYTES    = REG_W / 8;
    localparam int unsigned MAP_SPAN = WIN_COUNT * BYTES;

    if (!config_legal(REG_W, BYTE_SWAP)) begin : g_bad_cfg
        $error("gpio_mmio: width must be 8/16/32/64 and byte swap is not allowed at 64");
    end
    if ((64'd1 << ADDR_W) < 64'(MAP_SPAN)) begin : g_bad_addr
        $error("gpio_mmio: ADDR_W too narrow for the register windows");
    end

    wr_stb_t          stb;
    reg_sel_e         rsel;
    logic [REG_W-1:0] wpin;
    logic [REG_W-1:0] sync_q;
    logic [REG_W-1:0] dir_q;
    logic [REG_W-1:0] rval;
    logic [REG_W-1:0] rbus;

    gpio_mmio_decode #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .WR_MODE(WR_MODE), .DIR_MODE(DIR_MODE)
    ) u_decode (
        .addr(addr), .wr_en(wr_en), .stb(stb), .rsel(rsel)
    );

    gpio_mmio_order_map #(
        .REG_W(REG_W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)
    ) u_wmap (
        .din(wdata), .dout(wpin)
    );

    gpio_mmio_in_sync #(.REG_W(REG_W)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .sync_q(sync_q)
    );

    gpio_mmio_out_latch #(.REG_W(REG_W), .WR_MODE(WR_MODE)) u_latch (
        .clk(clk), .rst(rst),
        .wr_data(stb.data), .wr_set(stb.set), .wr_clr(stb.clr),
        .wpin(wpin), .q(pin_out)
    );

    gpio_mmio_dir_ctrl #(.REG_W(REG_W), .DIR_MODE(DIR_MODE)) u_dir (
        .clk(clk), .rst(rst), .wr_dir(stb.dir), .wpin(wpin),
        .dir_q(dir_q), .pin_oe(pin_oe)
    );

    // Read mux in pin order; clear window and unmapped offsets read zero
    always_comb begin
        case (rsel)
            SEL_DATA: rval = sync_q;
            SEL_SET:  rval = pin_out;
            SEL_DIR:  rval = dir_q;
            default:  rval = '0;
        endcase
    end

    gpio_mmio_order_map #(
        .REG_W(REG_W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)
    ) u_rmap (
        .din(rval), .dout(rbus)
    );

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rbus;
    end

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rsel == SEL_NONE)) |=> (rdata == '0));
    p_unmapped_nowr_r11: assert property (@(posedge clk) disable iff (rst)
        (rsel == SEL_NONE) |-> !(stb.data || stb.set || stb.clr || stb.dir));
endmodule

// File: tb/gpio_mmio_bench.sv
module gpio_mmio_bench;
    import gpio_mmio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [2:0]  wr_en = '0;
    logic [2:0]  rd_en = '0;
    logic [63:0] wdata = '0;

    logic [15:0] pin_in_a = 16'hA55A;
    logic [15:0] rdata_a, out_a, oe_a;
    logic [31:0] pin_in_b = 32'h0000_0001;
    logic [31:0] rdata_b, out_b, oe_b;
    logic [7:0]  pin_in_c = 8'h3C;
    logic [7:0]  rdata_c, out_c, oe_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 20 ns period, 50 MHz

    // A: 16-bit, set+clear, output-high direction, natural order
    gpio_mmio #(
        .REG_W(16), .ADDR_W(8), .WR_MODE(WR_SET_CLEAR), .DIR_MODE(DIR_OE_HIGH),
        .BIT_REV(1'b0), .BYTE_SWAP(1'b0)
    ) u_gpio_mmio (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en[0]), .rd_en(rd_en[0]),
        .wdata(wdata[15:0]), .rdata(rdata_a), .pin_in(pin_in_a),
        .pin_out(out_a), .pin_oe(oe_a)
    );

    // B: 32-bit, set-only, input-high direction, bit reversal and byte swap
    gpio_mmio #(
        .REG_W(32), .ADDR_W(8), .WR_MODE(WR_SET_ONLY), .DIR_MODE(DIR_IN_HIGH),
        .BIT_REV(1'b1), .BYTE_SWAP(1'b1)
    ) u_alt (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en[1]), .rd_en(rd_en[1]),
        .wdata(wdata[31:0]), .rdata(rdata_b), .pin_in(pin_in_b),
        .pin_out(out_b), .pin_oe(oe_b)
    );

    // C: 8-bit, data-only, no direction register
    gpio_mmio #(
        .REG_W(8), .ADDR_W(8), .WR_MODE(WR_DATA_ONLY), .DIR_MODE(DIR_NONE),
        .BIT_REV(1'b0), .BYTE_SWAP(1'b0)
    ) u_plain (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en[2]), .rd_en(rd_en[2]),
        .wdata(wdata[7:0]), .rdata(rdata_c), .pin_in(pin_in_c),
        .pin_out(out_c), .pin_oe(oe_c)
    );

    function automatic logic [31:0] bs32(logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] br32(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // bus word -> pin vector for build B (R9, R10)
    function automatic logic [31:0] b_pins(logic [31:0] bus);
        return br32(bs32(bus));
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the op's rising edge
    task automatic bus_op(input int dev, input bit is_rd, input logic [7:0] a,
                          input logic [63:0] d);
        addr  = a;
        wdata = d;
        if (is_rd) rd_en[dev] = 1'b1;
        else       wr_en[dev] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = '0;
        rd_en = '0;
    endtask

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  a;
        logic [15:0] d;
        logic [15:0] exp_out;
        logic [15:0] exp_oe;
        logic [3:0]  req;
    } vec_t;

    // Build A walk; pin_in_a held at A55A
    localparam vec_t TBL_A [0:15] = '{
        '{1'b0, 8'h00, 16'h1234, 16'h0000, 16'h0000, 4'd5},   // R5 data write ignored
        '{1'b0, 8'h02, 16'h00F0, 16'h00F0, 16'h0000, 4'd4},   // R4 set
        '{1'b0, 8'h02, 16'h0003, 16'h00F3, 16'h0000, 4'd4},   // R4 set keeps others
        '{1'b0, 8'h04, 16'h0030, 16'h00C3, 16'h0000, 4'd4},   // R4 clear
        '{1'b0, 8'h04, 16'h0000, 16'h00C3, 16'h0000, 4'd4},   // R4 zero mask
        '{1'b1, 8'h02, 16'h00C3, 16'h00C3, 16'h0000, 4'd4},   // R4 set reads latch
        '{1'b1, 8'h04, 16'h0000, 16'h00C3, 16'h0000, 4'd4},   // R4 clear reads zero
        '{1'b0, 8'h06, 16'hFF00, 16'h00C3, 16'hFF00, 4'd6},   // R6 direction
        '{1'b1, 8'h06, 16'hFF00, 16'h00C3, 16'hFF00, 4'd6},   // R6 readback
        '{1'b1, 8'h08, 16'h0000, 16'h00C3, 16'hFF00, 4'd11},  // R11 past last window
        '{1'b1, 8'h01, 16'h0000, 16'h00C3, 16'hFF00, 4'd11},  // R11 misaligned
        '{1'b0, 8'h08, 16'hFFFF, 16'h00C3, 16'hFF00, 4'd11},  // R11 write ignored
        '{1'b1, 8'h00, 16'hA55A, 16'h00C3, 16'hFF00, 4'd2},   // R2 data reads pins
        '{1'b0, 8'h02, 16'hFFFF, 16'hFFFF, 16'hFF00, 4'd4},   // R4 set all
        '{1'b0, 8'h04, 16'h8001, 16'h7FFE, 16'hFF00, 4'd4},   // R4 clear ends
        '{1'b0, 8'h06, 16'h00FF, 16'h7FFE, 16'h00FF, 4'd6}    // R6 flip direction
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 out_a", 64'(out_a), 64'h0);
        check("R1 oe_a", 64'(oe_a), 64'h0);
        check("R1 rdata_a", 64'(rdata_a), 64'h0);
        check("R1 out_b", 64'(out_b), 64'h0);
        check("R1 oe_b", 64'(oe_b), 64'hFFFF_FFFF);
        check("R1 oe_c", 64'(oe_c), 64'hFF);

        repeat (3) @(negedge clk);

        foreach (TBL_A[i]) begin
            bus_op(0, TBL_A[i].is_rd, TBL_A[i].a, 64'(TBL_A[i].d));
            if (TBL_A[i].is_rd)
                check($sformatf("R%0d A row %0d rdata", TBL_A[i].req, i),
                      64'(rdata_a), 64'(TBL_A[i].d));
            check($sformatf("R%0d A row %0d out", TBL_A[i].req, i),
                  64'(out_a), 64'(TBL_A[i].exp_out));
            check($sformatf("R%0d A row %0d oe", TBL_A[i].req, i),
                  64'(oe_a), 64'(TBL_A[i].exp_oe));
        end

        // R2 synchronizer depth: third back-to-back read sees new level
        pin_in_a = 16'h0F0F;
        bus_op(0, 1'b1, 8'h00, 64'h0);
        check("R2 read 1", 64'(rdata_a), 64'hA55A);
        bus_op(0, 1'b1, 8'h00, 64'h0);
        check("R2 read 2", 64'(rdata_a), 64'hA55A);
        bus_op(0, 1'b1, 8'h00, 64'h0);
        check("R2 read 3", 64'(rdata_a), 64'h0F0F);

        // R12 rdata holds across a write
        bus_op(0, 1'b0, 8'h04, 64'hFFFF);
        check("R12 rdata hold", 64'(rdata_a), 64'h0F0F);
        check("R4 clear all", 64'(out_a), 64'h0000);

        // Build B: R9 R10 mapping, R5 set-only, R7 polarity
        bus_op(1, 1'b0, 8'h04, 64'h0000_0001);
        check("R9 R10 single bit", 64'(out_b), 64'h0000_0080);
        bus_op(1, 1'b0, 8'h04, 64'h1234_5678);
        check("R5 set load", 64'(out_b), 64'(b_pins(32'h1234_5678)));
        bus_op(1, 1'b1, 8'h04, 64'h0);
        check("R5 set readback", 64'(rdata_b), 64'h1234_5678);
        bus_op(1, 1'b0, 8'h00, 64'hFFFF_FFFF);
        check("R5 data write ignored", 64'(out_b), 64'(b_pins(32'h1234_5678)));
        bus_op(1, 1'b1, 8'h00, 64'h0);
        check("R9 R10 data read", 64'(rdata_b), 64'h0000_0080);
        bus_op(1, 1'b0, 8'h0C, 64'h0000_00FF);
        check("R7 oe inverted", 64'(oe_b), 64'hFFFF_FF00);
        bus_op(1, 1'b1, 8'h0C, 64'h0);
        check("R7 dir readback", 64'(rdata_b), 64'h0000_00FF);
        bus_op(1, 1'b1, 8'h08, 64'h0);
        check("R11 absent clear reads zero", 64'(rdata_b), 64'h0);
        bus_op(1, 1'b0, 8'h08, 64'hFFFF_FFFF);
        check("R11 absent clear write", 64'(out_b), 64'(b_pins(32'h1234_5678)));

        // Build C: R3 data-only, R8 no direction
        bus_op(2, 1'b0, 8'h00, 64'h5A);
        check("R3 data load", 64'(out_c), 64'h5A);
        bus_op(2, 1'b1, 8'h00, 64'h0);
        check("R2 data reads pins", 64'(rdata_c), 64'h3C);
        bus_op(2, 1'b0, 8'h01, 64'hFF);
        check("R3 set offset ignored", 64'(out_c), 64'h5A);
        bus_op(2, 1'b0, 8'h03, 64'h00);
        check("R8 oe stays high", 64'(oe_c), 64'hFF);
        bus_op(2, 1'b1, 8'h03, 64'h0);
        check("R8 dir reads zero", 64'(rdata_c), 64'h0);
        bus_op(2, 1'b1, 8'h01, 64'h0);
        check("R3 set offset reads zero", 64'(rdata_c), 64'h0);

        finish_run();
    end
endmodule